// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block moves 8-bit bytes over two lines, a shift clock and a data line, in a clocked synchronous format. It can run as clock master, dividing the system clock to drive the shift clock out, or as clock slave, following an external shift clock that it synchronises into the system clock domain. Each byte is shifted out of and into a shift register. Software exchanges bytes through a transmit data register and a separate receive data register over a simple register write/read port.

Data bits change on falling edges of the shift clock and are sampled on rising edges. The shift clock idles high. A control bit chooses whether the most or the least significant bit travels first. A second control bit sets the data line level while no transfer is running. A received byte is copied to the receive data register and raises a receive-full flag, which software clears by reading that register. A byte that completes while the flag is still set is dropped and raises an overrun flag.

Top module: `sync_serial_port`

Register map (2-bit address): 0 = control (bit 0 master mode, bit 1 LSB-first, bit 2 idle data level), 1 = clock divisor, 2 = write transmit data / read receive data, 3 = status (read only: bit 0 receive full, bit 1 overrun). All control fields reset to 0.

## Requirements
- R1: After reset the port is a clock slave with MSB-first order and idle level 0. sck_o is 1, sck_oe is 0, sd_o is 0, and status and receive data read 0.
- R2: In master mode (control bit 0 = 1), sck_oe is 1. Writing address 2 starts a transfer of 8 low clock pulses on sck_o, and every high and low phase between the first and last edge lasts divisor+1 system clocks. sck_o stays high between transfers.
- R3: Transmit order follows control bit 1: 0 sends bit 7 first, 1 sends bit 0 first. A bit is driven on sd_o from a falling edge of the shift clock and held unchanged through the low phase up to the next rising edge.
- R4: The receiver samples sd_i on each rising edge of the shift clock and assembles the byte in the order set by control bit 1.
- R5: After the eighth rising edge the received byte appears at address 2 and status bit 0 (receive full) is set.
- R6: Reading address 2 clears status bit 0 and status bit 1.
- R7: If a byte completes while status bit 0 is set, status bit 1 (overrun) is set and address 2 keeps the earlier byte.
- R8: While no transfer is running, sd_o equals control bit 2.
- R9: In slave mode (control bit 0 = 0), sck_oe is 0 and sck_o is 1. The external clock on sck_i, passed through a two-flop synchroniser and an edge detector, shifts the data: bits are driven after its falling edges and sampled at its rising edges.
- R10: A slave transfer clocked without a transmit byte written sends the idle level (control bit 2) on every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 2 clears the flags) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from bus_addr |
| sck_i | input | 1 | External shift clock (slave mode) |
| sck_o | output | 1 | Generated shift clock (master mode) |
| sck_oe | output | 1 | Output enable for the clock line, high in master mode |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |

## Verification
Most faults in the shift engine show at the ports within one byte time. A wrong bit counter stretches or shortens the burst of clock pulses on sck_o. A wrong ordering flag or load value corrupts the serial bit pattern sampled in the low phase, and a broken receive shift returns a wrong byte one register read after the eighth rising edge. Flag faults show up on status reads: a missed clear leaves bit 0 set after the data read, and a wrong overrun path either replaces the held byte or fails to raise bit 1 after the second unread byte. Synchroniser or edge-detect faults in slave mode appear as sd_o changing too late or not at all before the bench raises the external clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_DIV  = 2'd1,
      ADDR_DATA = 2'd2,
      ADDR_STAT = 2'd3
   } ssp_addr_e;

   localparam int CTRL_MASTER = 0;
   localparam int CTRL_LSB    = 1;
   localparam int CTRL_IDLE   = 2;
   localparam int CTRL_BITS   = 3;

   localparam int STAT_FULL   = 0;
   localparam int STAT_OVR    = 1;
endpackage

// File: rtl/ssp_clk_div.sv
// Master shift-clock generator: half period is half_div+1 system clocks.
module ssp_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             sck,
   output logic             rise_p,
   output logic             fall_p
);
   logic [DIV_W-1:0] cnt_q;
   logic             sck_q;
   logic             tick;

   assign tick   = run && (cnt_q == half_div);
   assign fall_p = tick && sck_q;
   assign rise_p = tick && !sck_q;
   assign sck    = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (!run) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (tick) begin
         cnt_q <= '0;
         sck_q <= !sck_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ssp_edge_detect.sv
// Synchroniser chain plus edge detector for the external shift clock.
module ssp_edge_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   output logic rise_p,
   output logic fall_p
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], line};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_p = sync_q[STAGES-1] && !prev_q;
   assign fall_p = !sync_q[STAGES-1] && prev_q;
endmodule

// File: rtl/ssp_shift_engine.sv
// Shift engine: loads on the first falling edge, shifts out on later
// falling edges, samples on rising edges, finishes on the W-th sample.
module ssp_shift_engine #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rise_p,
   input  logic         fall_p,
   input  logic         lsb_first,
   input  logic         idle_lvl,
   input  logic         sd_in,
   input  logic         load_pend,
   input  logic [W-1:0] load_data,
   output logic         busy,
   output logic         sd_out,
   output logic         load_take,
   output logic         done_p,
   output logic [W-1:0] done_data
);
   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   logic [W-1:0]     tx_sh, rx_sh;
   logic [W-1:0]     load_val, load_rev, rx_next, rx_rev;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             start, shift, sample;

   assign load_val = load_pend ? load_data : {W{idle_lvl}};
   assign rx_next  = {rx_sh[W-2:0], sd_in};

   // Internal order is always MSB-first; reverse at both ends for LSB-first.
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign load_rev[i] = load_val[W-1-i];
      assign rx_rev[i]   = rx_next[W-1-i];
   end

   assign start     = fall_p && !busy_q;
   assign shift     = fall_p && busy_q;
   assign sample    = rise_p && busy_q;
   assign done_p    = sample && (cnt_q == LAST);
   assign load_take = start && load_pend;
   assign done_data = lsb_first ? rx_rev : rx_next;
   assign busy      = busy_q;
   assign sd_out    = busy_q ? tx_sh[W-1] : idle_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         rx_sh  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         if (start) begin
            tx_sh  <= lsb_first ? load_rev : load_val;
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (shift) begin
            tx_sh <= {tx_sh[W-2:0], idle_lvl};
         end
         if (sample) begin
            rx_sh <= rx_next;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
   import ssp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sd_i,
   output logic              sd_o
);
   if (DATA_W < CTRL_BITS) begin : g_bad_width
      $error("DATA_W must hold the control fields");
   end
   if (DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_div
      $error("DIV_W must be between 1 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              ctrl_master, ctrl_lsb, ctrl_idle;
   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] tx_q, rx_q;
   logic              tx_pend, rx_full, rx_ovr;

   logic gen_sck, gen_rise, gen_fall, ext_rise, ext_fall;
   logic sel_rise, sel_fall, busy, load_take, done_p;
   logic [DATA_W-1:0] done_data;
   logic wr_ctrl, wr_div, wr_data, rd_clr, clk_run;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_div  = bus_wr && (bus_addr == ADDR_DIV);
   assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
   assign rd_clr  = bus_rd && (bus_addr == ADDR_DATA);
   assign clk_run = ctrl_master && (tx_pend || busy);

   ssp_clk_div #(.DIV_W(DIV_W)) u_clk_div (
      .clk(clk), .rst_n(rst_n), .run(clk_run), .half_div(div_q),
      .sck(gen_sck), .rise_p(gen_rise), .fall_p(gen_fall)
   );

   ssp_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .line(sck_i),
      .rise_p(ext_rise), .fall_p(ext_fall)
   );

   assign sel_rise = ctrl_master ? gen_rise : ext_rise;
   assign sel_fall = ctrl_master ? gen_fall : ext_fall;

   ssp_shift_engine #(.W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .rise_p(sel_rise), .fall_p(sel_fall),
      .lsb_first(ctrl_lsb), .idle_lvl(ctrl_idle), .sd_in(sd_i),
      .load_pend(tx_pend), .load_data(tx_q), .busy(busy), .sd_out(sd_o),
      .load_take(load_take), .done_p(done_p), .done_data(done_data)
   );

   assign sck_o  = ctrl_master ? gen_sck : 1'b1;
   assign sck_oe = ctrl_master;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_master <= 1'b0;
         ctrl_lsb    <= 1'b0;
         ctrl_idle   <= 1'b0;
         div_q       <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_master <= bus_wdata[CTRL_MASTER];
            ctrl_lsb    <= bus_wdata[CTRL_LSB];
            ctrl_idle   <= bus_wdata[CTRL_IDLE];
         end
         if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         tx_pend <= 1'b0;
      end else if (wr_data) begin
         tx_q    <= bus_wdata;
         tx_pend <= 1'b1;
      end else if (load_take) begin
         tx_pend <= 1'b0;
      end
   end

   // A read in the same cycle as a completion lets the new byte in.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q    <= '0;
         rx_full <= 1'b0;
         rx_ovr  <= 1'b0;
      end else begin
         if (rd_clr) begin
            rx_full <= 1'b0;
            rx_ovr  <= 1'b0;
         end
         if (done_p) begin
            if (rx_full && !rd_clr) begin
               rx_ovr <= 1'b1;
            end else begin
               rx_q    <= done_data;
               rx_full <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (ssp_addr_e'(bus_addr))
         ADDR_CTRL: begin
            bus_rdata[CTRL_MASTER] = ctrl_master;
            bus_rdata[CTRL_LSB]    = ctrl_lsb;
            bus_rdata[CTRL_IDLE]   = ctrl_idle;
         end
         ADDR_DIV:  bus_rdata[DIV_W-1:0] = div_q;
         ADDR_DATA: bus_rdata = rx_q;
         default: begin
            bus_rdata[STAT_FULL] = rx_full;
            bus_rdata[STAT_OVR]  = rx_ovr;
         end
      endcase
   end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sck_o,
   input logic              sck_oe,
   input logic              sd_o,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic [DATA_W-1:0] rx_q,
   input logic              done_p,
   input logic              rd_clr
);
   // R2
   sck_fall_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck_o) |-> sck_oe);

   // R3
   sd_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && !sck_o && !$past(sck_o)) |-> $stable(sd_o));

   // R5
   full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(done_p));

   // R6
   full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !done_p) |=> !rx_full);

   // R7
   ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> $past(done_p && rx_full));

   // R7
   rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_clr) |=> $stable(rx_q));
endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .sck_oe(sck_oe), .sd_o(sd_o),
   .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_q(rx_q), .done_p(done_p),
   .rd_clr(rd_clr)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
   localparam int HS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       sck_i = 1'b1;
   logic       sck_o, sck_oe;
   logic       sd_i = 1'b0;
   logic       sd_o;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sync_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sd_i(sd_i), .sd_o(sd_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic int bitpos(input int k, input logic lsb);
      return lsb ? k : 7 - k;
   endfunction

   task automatic master_xfer(input logic [7:0] tx, input logic [7:0] feed,
                              input logic lsb, input logic [7:0] dv,
                              input logic idle);
      logic [7:0] cap, d;
      logic prev, cur, lvl;
      int k, run, guard;
      bus_write(2'd1, dv);
      bus_write(2'd0, {5'd0, idle, lsb, 1'b1});
      @(negedge clk);
      check("R8 idle level before master transfer", sd_o, idle);
      check("R2 master drives clock line", sck_oe, 1);
      sd_i = feed[bitpos(0, lsb)];
      bus_write(2'd2, tx);
      cap = '0; prev = 1'b1; cur = 1'b0; k = 0; run = 0; guard = 0;
      while (k < 8 && guard < 20000) begin
         @(negedge clk);
         guard++;
         lvl = sck_o;
         if (!lvl) cur = sd_o;
         if (lvl == prev) begin
            run++;
         end else begin
            if (!prev) check("R2 low phase length", run, dv + 1);
            else if (k > 0) check("R2 high phase length", run, dv + 1);
            run = 1;
            if (lvl) begin
               cap[bitpos(k, lsb)] = cur;
               k++;
               if (k < 8) sd_i = feed[bitpos(k, lsb)];
            end
         end
         prev = lvl;
      end
      check("R2 eight clock pulses", k, 8);
      repeat (3) @(negedge clk);
      check("R2 clock idles high", sck_o, 1);
      check("R8 idle level after master transfer", sd_o, idle);
      check("R3 master transmit bit order", cap, tx);
      bus_read(2'd3, d);
      check("R5 receive full after byte", d, 8'h01);
      bus_read(2'd2, d);
      check("R4 master received byte", d, feed);
      bus_read(2'd3, d);
      check("R6 flags cleared by data read", d, 8'h00);
   endtask

   task automatic slave_xfer(input logic [7:0] feed, input logic lsb,
                             input logic idle, input logic wr_tx,
                             input logic [7:0] tx, input logic [7:0] exp_tx);
      logic [7:0] cap;
      bus_write(2'd0, {5'd0, idle, lsb, 1'b0});
      if (wr_tx) bus_write(2'd2, tx);
      @(negedge clk);
      check("R9 slave leaves clock line undriven", sck_oe, 0);
      check("R9 slave clock output high", sck_o, 1);
      cap = '0;
      for (int k = 0; k < 8; k++) begin
         repeat (HS) @(negedge clk);
         sck_i = 1'b0;
         sd_i = feed[bitpos(k, lsb)];
         repeat (HS) @(negedge clk);
         cap[bitpos(k, lsb)] = sd_o;
         sck_i = 1'b1;
      end
      repeat (HS) @(negedge clk);
      check("R9 slave transmit bits (R3 order)", cap, exp_tx);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 reset sck_o", sck_o, 1);
      check("R1 reset sck_oe", sck_oe, 0);
      check("R1 reset sd_o", sd_o, 0);
      bus_read(2'd3, d);
      check("R1 reset status", d, 0);
      bus_read(2'd2, d);
      check("R1 reset receive data", d, 0);
   endtask

   task automatic t_idle_level;
      bus_write(2'd0, 8'h04);
      @(negedge clk);
      check("R8 idle level high", sd_o, 1);
      bus_write(2'd0, 8'h00);
      @(negedge clk);
      check("R8 idle level low", sd_o, 0);
   endtask

   task automatic t_master;
      master_xfer(8'hA5, 8'h3C, 1'b0, 8'd1, 1'b0);
      master_xfer(8'h1E, 8'hC9, 1'b1, 8'd3, 1'b1);
      master_xfer(8'h80, 8'h01, 1'b0, 8'd0, 1'b1);
   endtask

   task automatic t_slave;
      logic [7:0] d;
      slave_xfer(8'h6B, 1'b0, 1'b0, 1'b1, 8'hD2, 8'hD2);
      bus_read(2'd2, d);
      check("R9 slave received byte MSB first", d, 8'h6B);
      slave_xfer(8'h35, 1'b1, 1'b0, 1'b1, 8'h4E, 8'h4E);
      bus_read(2'd2, d);
      check("R4 slave received byte LSB first", d, 8'h35);
   endtask

   task automatic t_no_data;
      logic [7:0] d;
      // R10: no transmit byte written, idle level 1 goes out on every bit
      slave_xfer(8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF);
      bus_read(2'd2, d);
      check("R10 byte received alongside idle bits", d, 8'h00);
   endtask

   task automatic t_overrun;
      logic [7:0] d;
      slave_xfer(8'h5A, 1'b0, 1'b0, 1'b1, 8'h11, 8'h11);
      slave_xfer(8'hC3, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
      bus_read(2'd3, d);
      check("R7 overrun and full both set", d, 8'h03);
      bus_read(2'd2, d);
      check("R7 earlier byte kept", d, 8'h5A);
      bus_read(2'd3, d);
      check("R6 read clears overrun and full", d, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_idle_level;
      t_master;
      t_slave;
      t_no_data;
      t_overrun;
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule